// File: doc/BRIEF.md
# Regulator Undervoltage Retry Controller

This block supervises the standby 3.3 V linear regulator of a power-sequencing controller. Out of power-on reset it enables the regulator and flags an initial soft-start ramp. Once that ramp interval ends, it watches an undervoltage comparator flag, but only while the system is in a sleep state. A fault drops the regulator enable. The block then waits one soft-start interval and re-enables the regulator through a fresh ramp.

The regulator may be restarted three times. The fourth fault shuts it down for good and raises a latched-fault output, and only the next power-on reset clears that condition. Overcurrent has no input of its own. Foldback pulls the output below the trip point, and the comparator flag then starts the same retry path. Soft-start intervals are marked by a one-cycle tick that a separate timer supplies.

Top module: `uvr_retry_top`

## Requirements
- R1: While and after power-on reset (rst_n low), the outputs are reg_en_o=1, ramp_o=1 and fault_latched_o=0, and the fault count is zero.
- R2: A ramp, whether initial or a retry, ends at the first soft-start tick. After that tick, ramp_o=0 and reg_en_o stays 1 (monitoring).
- R3: uv_i is ignored while ramp_o=1. reg_en_o stays 1 and ramp_o stays 1 until the tick.
- R4: uv_i is ignored while sleep_i=0 (system active), even when monitoring.
- R5: When monitoring with sleep_i=1, a uv_i sampled high at a clock edge makes reg_en_o=0 and ramp_o=0 after that edge.
- R6: After a fault, reg_en_o stays 0 until the next soft-start tick. After that tick, reg_en_o=1 and ramp_o=1 (retry ramp).
- R7: The first three faults each start a retry. The fourth fault sets fault_latched_o=1 and reg_en_o=0. Both stay that way whatever the inputs do, ticks included.
- R8: The fault count is not cleared by time spent with sleep_i=0. Only rst_n clears the count and the latch.
- R9: After a power-on reset that follows a latch, a full set of three retries is available again before the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| sleep_i | input | 1 | 1 while the system is in a sleep state |
| uv_i | input | 1 | Undervoltage comparator flag, 1 = output below trip point |
| ss_tick_i | input | 1 | One-cycle pulse marking the end of a soft-start interval |
| reg_en_o | output | 1 | Regulator enable |
| ramp_o | output | 1 | 1 while a soft-start ramp is in progress |
| fault_latched_o | output | 1 | 1 while the regulator is permanently disabled |

## Verification
The assertions check several rules on every cycle: a qualified fault drops the enable on the next edge, the enable comes back only on a tick, a ramp always has the enable set, the latch never releases and keeps the enable low, and the count never passes its limit. Some behaviour only the directed scenarios can show. These are the exact retry count before the latch, the count surviving an active period, the flag being ignored during ramps and while active, and the fresh retry budget after reset.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    ST_RAMP = 2'd0,
    ST_MON  = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOCK = 2'd3
  } uvr_state_e;
endpackage

// File: rtl/uvr_retry_cnt.sv
module uvr_retry_cnt #(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  output logic exhausted_o
);
  localparam int CNT_W = $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign exhausted_o = (cnt_q == CNT_MAX);
  assign cnt_en      = fault_i && !exhausted_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R7
  AST_CNT_ONLY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/uvr_fault_fsm.sv
module uvr_fault_fsm
  import uvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_i,
  input  logic       uv_i,
  input  logic       tick_i,
  input  logic       exhausted_i,
  output logic       fault_o,
  output uvr_state_e state_o
);
  uvr_state_e state_q, state_d;

  assign fault_o = (state_q == ST_MON) && sleep_i && uv_i;
  assign state_o = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RAMP: if (tick_i) state_d = ST_MON;
      ST_MON:  if (fault_o) state_d = exhausted_i ? ST_LOCK : ST_WAIT;
      ST_WAIT: if (tick_i) state_d = ST_RAMP;
      ST_LOCK: state_d = ST_LOCK;
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RAMP;
    else        state_q <= state_d;
  end

  AST_RAMP_EXIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && !tick_i) |=> state_q == ST_RAMP); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !tick_i) |=> state_q == ST_WAIT); // R6
endmodule

// File: rtl/uvr_retry_top.sv
module uvr_retry_top
  import uvr_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic uv_i,
  input  logic ss_tick_i,
  output logic reg_en_o,
  output logic ramp_o,
  output logic fault_latched_o
);
  logic       fault;
  logic       exhausted;
  uvr_state_e state;

  uvr_fault_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .uv_i        (uv_i),
    .tick_i      (ss_tick_i),
    .exhausted_i (exhausted),
    .fault_o     (fault),
    .state_o     (state)
  );

  uvr_retry_cnt #(.MAX_RETRY(MAX_RETRY)) i_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault),
    .exhausted_o (exhausted)
  );

  assign reg_en_o        = (state == ST_RAMP) || (state == ST_MON);
  assign ramp_o          = (state == ST_RAMP);
  assign fault_latched_o = (state == ST_LOCK);

  AST_FAULT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en_o && !ramp_o && sleep_i && uv_i) |=> !reg_en_o); // R5
  AST_EN_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en_o) |-> $past(ss_tick_i)); // R6
  AST_RAMP_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_o |-> reg_en_o); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched_o |=> fault_latched_o); // R8
  AST_LOCK_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched_o |-> !reg_en_o); // R7
  AST_ACTIVE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en_o && !ramp_o && !sleep_i) |=> reg_en_o); // R4
endmodule

// File: tb/test_uvr_retry_top.sv
module test_uvr_retry_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, sleep_i, uv_i, ss_tick_i;
  logic reg_en_o, ramp_o, fault_latched_o;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uvr_retry_top i_uvr_retry_top (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .uv_i(uv_i),
    .ss_tick_i(ss_tick_i), .reg_en_o(reg_en_o), .ramp_o(ramp_o),
    .fault_latched_o(fault_latched_o)
  );

  task automatic check(string req, logic [2:0] exp);
    logic [2:0] act;
    act = {reg_en_o, ramp_o, fault_latched_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {en,ramp,latched} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_i = 1'b0; uv_i = 1'b0; ss_tick_i = 1'b0;
    idle(3);
    check("R1 in reset", 3'b110);
    rst_n = 1'b1;
    idle(1);
    check("R1 after reset", 3'b110);
  endtask

  task automatic tick();
    ss_tick_i = 1'b1; idle(1); ss_tick_i = 1'b0;
  endtask

  task automatic uv_pulse();
    uv_i = 1'b1; idle(1); uv_i = 1'b0;
  endtask

  task automatic fault_and_retry(string tag);
    sleep_i = 1'b1;
    uv_pulse();
    check({tag, " R5 fault drops enable"}, 3'b000);
    idle(4);
    check({tag, " R6 waits for tick"}, 3'b000);
    tick();
    check({tag, " R6 retry ramp"}, 3'b110);
    tick();
    check({tag, " R2 retry ramp ends"}, 3'b100);
  endtask

  task automatic t_initial_ramp();
    sleep_i = 1'b1;
    uv_pulse();
    idle(2);
    check("R3 uv ignored in initial ramp", 3'b110);
    tick();
    check("R2 initial ramp ends", 3'b100);
  endtask

  task automatic t_active_ignored();
    sleep_i = 1'b0;
    uv_i = 1'b1; idle(3); uv_i = 1'b0;
    check("R4 uv ignored while active", 3'b100);
  endtask

  task automatic t_retries_and_lock();
    fault_and_retry("f1");
    sleep_i = 1'b1;
    uv_pulse();
    tick();
    uv_pulse();
    check("R3 uv ignored in retry ramp", 3'b110);
    tick();
    check("R2 second retry ramp ends", 3'b100);
    sleep_i = 1'b0; idle(5); tick(); idle(2);
    check("R8 active period", 3'b100);
    fault_and_retry("f3");
    sleep_i = 1'b1;
    uv_pulse();
    check("R7 fourth fault latches", 3'b001);
    tick(); idle(1); tick();
    sleep_i = 1'b0; uv_pulse();
    check("R7 latch holds through ticks", 3'b001);
  endtask

  task automatic t_reset_clears();
    do_reset();
    check("R8 reset clears latch", 3'b110);
    tick();
    fault_and_retry("R9 r1");
    fault_and_retry("R9 r2");
    fault_and_retry("R9 r3");
    check("R9 three retries without latch", 3'b100);
    sleep_i = 1'b1;
    uv_pulse();
    check("R9 fourth fault latches", 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_initial_ramp();
    t_active_ignored();
    t_retries_and_lock();
    t_reset_clears();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule